// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Generator

This block drives one active-high pulse-width-modulated output from a free-running 8-bit counter. The counter steps once for each pulse of a slow clock-enable input, nominally 32 kHz. There is no period register. A 2-bit prescaler field instead picks which counter bit clears the counter as soon as that bit becomes set. The period is therefore 128, 64, 32 or 16 ticks, and the number of compare bits shrinks as the frequency rises.

A host writes and reads two byte-wide registers through a plain write strobe, a one-bit address and a combinational read path. Address 0 is control: bit 7 enables the generator and bits 1:0 hold the prescaler. Address 1 holds a 7-bit duty value. The output is high while the counter bits below the selected reset bit are less than the duty value. Every register write acts in the cycle after the strobe. The counter is not cleared on a prescaler change, and a duty change does not wait for a period boundary, so software must order its writes to avoid glitches.

Top module: `pwm_prescaled`

## Requirements
- R1: A synchronous reset clears enable, prescaler, duty and the counter, and drives the output low.
- R2: Address 0 reads {enable, 5'b0, prescaler[1:0]} with enable in bit 7, so bits 6:2 read zero. Address 1 reads {1'b0, duty[6:0]}, and bit 7 of a duty write is dropped.
- R3: While enabled, the counter advances only in cycles with the tick input high. For prescaler p it wraps after 2^(7-p) ticks, giving periods of 128, 64, 32 and 16 ticks for p = 0..3.
- R4: While enabled, the output is high exactly when the counter bits below bit 7-p are less than the duty value. A duty of 0 gives a constant low output.
- R5: A duty value at or above the full scale 2^(7-p) keeps the output high for the whole period. With prescaler 0 the maximum duty of 127 still leaves one low tick in every 128.
- R6: While disabled, the counter holds at zero and the output is low. After enable is set, counting restarts from zero.
- R7: A prescaler write does not clear the counter. The new reset bit takes effect from the next tick, which can shorten the period in progress.
- R8: A duty write changes the compare value in the cycle after the strobe, in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Counter step enable (nominally 32 kHz) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 duty |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| pwm_out | output | 1 | PWM output, active high |

## Verification
A register write and a counter tick can land on the same clock edge. In that case the counter step and the wrap decision use the old settings, and the compare after the edge uses the new ones. The bench keeps tick high during its enable, prescaler and duty writes so that these edges always coincide. It then judges the output sample by sample: the first compare value after the write must already be the new one, and a mid-period prescaler change must carry the uncleared counter on to the new wrap point.

// File: rtl/pwm_prescaled.sv
module pwm_prescaled #(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_out
);
  localparam int DUTY_W = CNT_W - 1;
  localparam int IDX_W  = $clog2(CNT_W);
  localparam int EN_BIT = DATA_W - 1;
  localparam int PAD_W  = DATA_W - 1 - PRE_W;

  logic              en_q;
  logic [PRE_W-1:0]  pre_q;
  logic [DUTY_W-1:0] duty_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_inc;
  logic [CNT_W-1:0]  full_scale;
  logic [CNT_W-1:0]  low_bits;
  logic [IDX_W-1:0]  wrap_bit;

  assign wrap_bit   = IDX_W'(CNT_W - 1) - IDX_W'(pre_q);
  assign full_scale = CNT_W'(1) << wrap_bit;
  assign low_bits   = cnt_q & (full_scale - CNT_W'(1));
  assign cnt_inc    = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pre_q  <= '0;
      duty_q <= '0;
    end else if (wr_en) begin
      if (!addr) begin
        en_q  <= wdata[EN_BIT];
        pre_q <= wdata[PRE_W-1:0];
      end else begin
        duty_q <= wdata[DUTY_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en_q)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= cnt_inc[wrap_bit] ? '0 : cnt_inc;
  end

  assign pwm_out = en_q && (low_bits < CNT_W'(duty_q));
  assign rdata   = addr ? DATA_W'(duty_q) : {en_q, {PAD_W{1'b0}}, pre_q};

endmodule

// File: rtl/pwm_prescaled_chk.sv
module pwm_prescaled_chk #(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              addr,
  input logic [DATA_W-1:0] rdata,
  input logic              pwm_out,
  input logic              en_q,
  input logic [PRE_W-1:0]  pre_q,
  input logic [CNT_W-2:0]  duty_q,
  input logic [CNT_W-1:0]  cnt_q
);
  logic rst_d;
  int   top_val;

  assign top_val = 1 << (CNT_W - 1 - int'(pre_q));

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d)
      a_r1_cleared: assert (cnt_q == '0 && !en_q && pre_q == '0 && duty_q == '0 && !pwm_out)
        else $error("R1 state not cleared by reset");
  end

  a_r2_pad_zero: assert property (@(posedge clk) disable iff (rst)
    !addr |-> rdata[DATA_W-2:PRE_W] == '0);

  a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (en_q && !tick) |=> $stable(cnt_q));

  a_r4_zero_duty_low: assert property (@(posedge clk) disable iff (rst)
    (duty_q == '0) |-> !pwm_out);

  a_r5_full_high: assert property (@(posedge clk) disable iff (rst)
    (en_q && int'(duty_q) >= top_val) |-> pwm_out);

  a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !pwm_out);

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> cnt_q == '0);

endmodule

bind pwm_prescaled pwm_prescaled_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .addr(addr), .rdata(rdata), .pwm_out(pwm_out),
  .en_q(en_q), .pre_q(pre_q), .duty_q(duty_q), .cnt_q(cnt_q)
);

// File: tb/pwm_prescaled_bench.sv
module pwm_prescaled_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pwm_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  pwm_prescaled u_pwm_prescaled (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  always #2 clk = ~clk;

  // {prescaler, duty, window cycles, expected high cycles}
  localparam int NV = 13;
  localparam int VEC [NV][4] = '{
    '{0,   0, 128,   0}, '{0,   1, 128,   1}, '{0,  64, 128,  64},
    '{0, 127, 128, 127}, '{1,  33,  64,  33}, '{1,  64,  64,  64},
    '{1, 100,  64,  64}, '{2,   7,  32,   7}, '{2,  32,  32,  32},
    '{3,  15,  16,  15}, '{3,  16,  16,  16}, '{2,   3,  96,   9},
    '{3,   5,  48,  15}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out) h++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    int v, h, lows;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(1'b0, v); chk("R1 ctrl after reset", v, 0);
    rd(1'b1, v); chk("R1 duty after reset", v, 0);
    chk("R1 output after reset", int'(pwm_out), 0);

    // R2: readback and dropped bits
    wr(1'b0, 8'hFF); rd(1'b0, v); chk("R2 ctrl readback", v, 8'h83);
    wr(1'b1, 8'hFF); rd(1'b1, v); chk("R2 duty readback", v, 8'h7F);
    wr(1'b0, 8'h00);

    // R3 R4 R5: vector walk, tick held high across writes
    tick = 1'b1;
    for (int k = 0; k < NV; k++) begin
      wr(1'b0, 8'h00);
      wr(1'b1, 8'(VEC[k][1]));
      wr(1'b0, 8'h80 | 8'(VEC[k][0]));
      count_high(VEC[k][2], h);
      chk($sformatf("R3 R4 R5 vec%0d p%0d d%0d", k, VEC[k][0], VEC[k][1]), h, VEC[k][3]);
    end

    // R6: disabled output low, counter restart at zero
    wr(1'b0, 8'h00); wr(1'b1, 8'd50);
    count_high(100, h); chk("R6 disabled output low", h, 0);
    wr(1'b1, 8'd4); wr(1'b0, 8'h83);
    count_high(10, h);
    wr(1'b0, 8'h03); wr(1'b0, 8'h83);
    chk("R6 first sample after enable", int'(pwm_out), 1);
    count_high(16, h); chk("R6 restart from zero", h, 4);

    // R3: counter steps only on tick (period 16 ticks, tick every 4 cycles)
    wr(1'b0, 8'h00); wr(1'b1, 8'd3); wr(1'b0, 8'h83);
    tick = 1'b0;
    count_high(20, h); chk("R3 no tick holds counter", h, 20);
    wr(1'b0, 8'h00); wr(1'b0, 8'h83);
    h = 0;
    for (int k = 0; k < 64; k++) begin
      if (pwm_out) h++;
      tick = (k % 4 == 3);
      @(negedge clk);
    end
    chk("R3 sparse tick high count", h, 12);
    tick = 1'b1;

    // R7: prescaler change keeps counter (40 -> 42 at p3, wraps after 47)
    wr(1'b0, 8'h00); wr(1'b1, 8'd5); wr(1'b0, 8'h80);
    repeat (40) @(negedge clk);
    wr(1'b0, 8'h83);
    lows = 0;
    for (int k = 0; k < 20 && !pwm_out; k++) begin
      lows++;
      @(negedge clk);
    end
    chk("R7 low samples before wrap", lows, 6);

    // R8: duty write acts at once mid-period
    wr(1'b0, 8'h00); wr(1'b1, 8'd100); wr(1'b0, 8'h80);
    repeat (48) @(negedge clk);
    chk("R8 high before duty write", int'(pwm_out), 1);
    wr(1'b1, 8'd10);
    chk("R8 low right after duty write", int'(pwm_out), 0);

    // R1: reset while running
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 output after mid-run reset", int'(pwm_out), 0);
    rd(1'b0, v); chk("R1 ctrl after mid-run reset", v, 0);
    rd(1'b1, v); chk("R1 duty after mid-run reset", v, 0);

    done = 1;
    summary();
  end
endmodule